// File: doc/BRIEF.md
# Variable-Width Double-Rate Link Packer

This block sits between a packet source that produces 32-bit words and a point-to-point parallel link whose lane count is set at run time to 2, 4, 8, 16 or 32 lanes. The transmit half slices each accepted word into beats as wide as the active lane count. It sends two beats per internal clock cycle to model transfer on both clock edges. A control line travels with every beat and says whether the word belongs to a control packet or to a data packet. The receive half collects the beats of one word back into a 32-bit word and restores its control flag.

The source side uses a valid/ready handshake. A new lane count can be requested at any time. It is held in a pending register and takes effect only once the word in flight has been fully sent, so a word is never split across two widths. Both halves sit in one top module. The link outputs of the transmit half and the link inputs of the receive half are separate ports, so the two can be wired to opposite ends of a real link or looped back.

Top module: `ddr_link_packer`

## Requirements
- R1: After reset, in_ready is high, no link beat is valid, out_valid is low, and the active transmit width is 8 lanes.
- R2: Beat j of a word (counting from 0) carries word bits [j*W+W-1 : j*W] on lanes W-1..0, with lane 0 carrying the lowest of those bits. In each cycle the first beat (lo) comes before the second (hi). Lanes at or above W are driven to 0.
- R3: For widths of 2 and 4 lanes, each byte is sent over 8/W consecutive beats, lowest bits first, and byte k+1 starts on the beat after byte k ends.
- R4: For widths of 16 and 32 lanes, byte k of a word goes on lane group (k mod W/8), lanes 8g+7..8g, of beat k/(W/8).
- R5: A word takes 32/W beats. Two are sent per cycle, so a word takes 8, 4, 2 or 1 cycles for 2, 4, 8 or 16 lanes. At 32 lanes a word takes one cycle and uses only the first beat. The hi beat is never valid without the lo beat.
- R6: in_ready is high exactly when nothing is in flight or when the current word's last beats go out this cycle. A word accepted at a clock edge starts its beats in the next cycle, so words stream with no idle gap.
- R7: lo_ctl and hi_ctl equal the control flag of the word being sent on every valid beat, hold that value for all beats of the word, and are 0 on beats that are not valid.
- R8: Width codes are 0=2, 1=4, 2=8, 3=16 and 4=32 lanes. A request takes effect for the first word accepted in a cycle after the request cycle in which in_ready is high. The word already in flight finishes at the old width. If several requests come before that point, the latest one wins.
- R9: A width request with a code of 5, 6 or 7 is ignored, and the active width is unchanged.
- R10: The receive half, given the same width code, outputs each rebuilt word with its control flag as a one-cycle out_valid pulse. The pulse comes in the cycle after the cycle that carried the word's last beat, and words come out in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; each cycle carries two link beats |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Width change request strobe |
| cfg_code | input | 3 | Requested width code (0..4 valid) |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Packer can take a word this cycle |
| in_word | input | 32 | Source word |
| in_ctl | input | 1 | 1 = word belongs to a control packet |
| tx_lo_data | output | 32 | First beat of the cycle, lane 0 at bit 0 |
| tx_hi_data | output | 32 | Second beat of the cycle |
| tx_lo_vld | output | 1 | First beat carries data |
| tx_hi_vld | output | 1 | Second beat carries data |
| tx_lo_ctl | output | 1 | Control line for the first beat |
| tx_hi_ctl | output | 1 | Control line for the second beat |
| rx_code | input | 3 | Width code used by the receive half |
| rx_lo_data | input | 32 | Received first beat |
| rx_hi_data | input | 32 | Received second beat |
| rx_lo_vld | input | 1 | Received first beat is valid |
| rx_hi_vld | input | 1 | Received second beat is valid |
| rx_lo_ctl | input | 1 | Control line of the received first beat |
| rx_hi_ctl | input | 1 | Control line of the received second beat |
| out_valid | output | 1 | Rebuilt word strobe |
| out_word | output | 32 | Rebuilt word |
| out_ctl | output | 1 | Control flag of the rebuilt word |

## Verification
The bench builds the block with the package defaults: 32-bit words and up to 32 lanes. Because the lane count is a run-time input, this one build covers every width. That includes the 16-beat narrow case at 2 lanes, where one byte spans four beats, and the 32-lane case, where a word fits in a single beat and the second beat of each cycle stays empty. Looping the link outputs back into the receive half lets random traffic at each width be checked end to end. A width change requested in the middle of a 2-lane word shows the deferral at a word boundary.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int WORD_W    = 32;
    localparam int LANES_MAX = WORD_W;              // widest link equals one word
    localparam int CODE_W    = 3;
    localparam int NUM_CODES = 5;
    localparam int CNT_W     = $clog2(WORD_W / 2 + 1);

    typedef enum logic [CODE_W-1:0] {
        LW2  = 3'd0,
        LW4  = 3'd1,
        LW8  = 3'd2,
        LW16 = 3'd3,
        LW32 = 3'd4
    } lane_code_e;

    // log2 of the lane count
    function automatic int unsigned lane_shift(lane_code_e c);
        return int'(c) + 1;
    endfunction

    function automatic int unsigned lane_count(lane_code_e c);
        return 1 << lane_shift(c);
    endfunction

    function automatic logic [CNT_W-1:0] beats_per_word(lane_code_e c);
        return CNT_W'(WORD_W >> lane_shift(c));
    endfunction

    function automatic logic [LANES_MAX-1:0] lane_mask(lane_code_e c);
        logic [LANES_MAX:0] bit_at_w;
        bit_at_w = '0;
        bit_at_w[lane_count(c)] = 1'b1;
        return LANES_MAX'(bit_at_w - 1'b1);
    endfunction

    function automatic logic code_ok(logic [CODE_W-1:0] c);
        return int'(c) < NUM_CODES;
    endfunction

endpackage

// File: rtl/lp_tx_packer.sv
module lp_tx_packer
    import lp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic [CODE_W-1:0]    cfg_code,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_word,
    input  logic                 in_ctl,
    output logic [LANES_MAX-1:0] lo_data,
    output logic [LANES_MAX-1:0] hi_data,
    output logic                 lo_vld,
    output logic                 hi_vld,
    output logic                 lo_ctl,
    output logic                 hi_ctl
);

    typedef struct packed {
        lane_code_e        width;
        logic              pend_vld;
        lane_code_e        pend;
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  rem;
        logic              ctl;
    } tx_state_t;

    localparam tx_state_t TX_RST = '{width: LW8, pend_vld: 1'b0, pend: LW8,
                                     sh: '0, rem: '0, ctl: 1'b0};

    tx_state_t s_q, s_d;
    logic      at_bound;

    always_comb begin
        int unsigned      wb;
        logic [CNT_W-1:0] sent;
        s_d      = s_q;
        wb       = lane_count(s_q.width);
        lo_vld   = s_q.rem != '0;
        hi_vld   = s_q.rem >= CNT_W'(2);
        lo_data  = s_q.sh & lane_mask(s_q.width);
        hi_data  = hi_vld ? ((s_q.sh >> wb) & lane_mask(s_q.width)) : '0;
        lo_ctl   = lo_vld & s_q.ctl;
        hi_ctl   = hi_vld & s_q.ctl;
        at_bound = s_q.rem <= CNT_W'(2);
        in_ready = at_bound;
        sent     = hi_vld ? CNT_W'(2) : (lo_vld ? CNT_W'(1) : '0);
        s_d.sh   = s_q.sh >> (2 * wb);
        s_d.rem  = s_q.rem - sent;
        if (at_bound && s_q.pend_vld) begin
            s_d.width    = s_q.pend;
            s_d.pend_vld = 1'b0;
        end
        if (cfg_valid && code_ok(cfg_code)) begin
            s_d.pend_vld = 1'b1;
            s_d.pend     = lane_code_e'(cfg_code);
        end
        if (at_bound && in_valid) begin
            s_d.sh  = in_word;
            s_d.rem = beats_per_word(s_d.width);
            s_d.ctl = in_ctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= TX_RST;
        else        s_q <= s_d;
    end

    // R5
    hi_needs_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_vld |-> lo_vld);

    // R6
    accept_then_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> lo_vld);

    // R7
    ctl_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_vld && !in_ready) |=> (lo_vld && lo_ctl == $past(lo_ctl)));

    // R7
    ctl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_vld |-> (hi_ctl == lo_ctl));

    // R8
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_vld && !in_ready) |=> $stable(s_q.width));

endmodule

// File: rtl/lp_rx_unpacker.sv
module lp_rx_unpacker
    import lp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CODE_W-1:0]    code,
    input  logic [LANES_MAX-1:0] lo_data,
    input  logic [LANES_MAX-1:0] hi_data,
    input  logic                 lo_vld,
    input  logic                 hi_vld,
    input  logic                 lo_ctl,
    input  logic                 hi_ctl,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_word,
    output logic                 out_ctl
);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              ctl;
    } rx_state_t;

    rx_state_t s_q, s_d;

    always_comb begin
        lane_code_e           wc;
        int unsigned          wb;
        logic [LANES_MAX-1:0] beat;
        logic                 bv;
        logic                 bc;
        s_d     = s_q;
        s_d.vld = 1'b0;
        wc      = code_ok(code) ? lane_code_e'(code) : LW8;
        wb      = lane_count(wc);
        for (int b = 0; b < 2; b++) begin
            beat = (b == 0) ? lo_data : hi_data;
            bv   = (b == 0) ? lo_vld  : hi_vld;
            bc   = (b == 0) ? lo_ctl  : hi_ctl;
            if (bv) begin
                s_d.acc = s_d.acc | (WORD_W'(beat & lane_mask(wc)) << (int'(s_d.cnt) * wb));
                s_d.cnt = s_d.cnt + CNT_W'(1);
                if (s_d.cnt == beats_per_word(wc)) begin
                    s_d.vld  = 1'b1;
                    s_d.word = s_d.acc;
                    s_d.ctl  = bc;
                    s_d.acc  = '0;
                    s_d.cnt  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_word  = s_q.word;
    assign out_ctl   = s_q.ctl;

    // R10
    rx_out_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(lo_vld || hi_vld));

endmodule

// File: rtl/ddr_link_packer.sv
module ddr_link_packer
    import lp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic [CODE_W-1:0]    cfg_code,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_word,
    input  logic                 in_ctl,
    output logic [LANES_MAX-1:0] tx_lo_data,
    output logic [LANES_MAX-1:0] tx_hi_data,
    output logic                 tx_lo_vld,
    output logic                 tx_hi_vld,
    output logic                 tx_lo_ctl,
    output logic                 tx_hi_ctl,
    input  logic [CODE_W-1:0]    rx_code,
    input  logic [LANES_MAX-1:0] rx_lo_data,
    input  logic [LANES_MAX-1:0] rx_hi_data,
    input  logic                 rx_lo_vld,
    input  logic                 rx_hi_vld,
    input  logic                 rx_lo_ctl,
    input  logic                 rx_hi_ctl,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_word,
    output logic                 out_ctl
);

    lp_tx_packer tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_code  (cfg_code),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_word   (in_word),
        .in_ctl    (in_ctl),
        .lo_data   (tx_lo_data),
        .hi_data   (tx_hi_data),
        .lo_vld    (tx_lo_vld),
        .hi_vld    (tx_hi_vld),
        .lo_ctl    (tx_lo_ctl),
        .hi_ctl    (tx_hi_ctl)
    );

    lp_rx_unpacker rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .code      (rx_code),
        .lo_data   (rx_lo_data),
        .hi_data   (rx_hi_data),
        .lo_vld    (rx_lo_vld),
        .hi_vld    (rx_hi_vld),
        .lo_ctl    (rx_lo_ctl),
        .hi_ctl    (rx_hi_ctl),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_ctl   (out_ctl)
    );

endmodule

// File: tb/ddr_link_packer_tb_top.sv
module ddr_link_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_valid;
    logic [2:0]  cfg_code;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic        in_ctl;
    logic [31:0] lo_data, hi_data;
    logic        lo_vld, hi_vld, lo_ctl, hi_ctl;
    logic [2:0]  rx_code;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_ctl;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc_n  = 0;
    bit finished = 0;
    logic [32:0] exp_q[$];

    always #5 clk = ~clk;

    ddr_link_packer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_code(cfg_code),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_ctl(in_ctl),
        .tx_lo_data(lo_data), .tx_hi_data(hi_data), .tx_lo_vld(lo_vld), .tx_hi_vld(hi_vld),
        .tx_lo_ctl(lo_ctl), .tx_hi_ctl(hi_ctl), .rx_code(rx_code),
        .rx_lo_data(lo_data), .rx_hi_data(hi_data), .rx_lo_vld(lo_vld), .rx_hi_vld(hi_vld),
        .rx_lo_ctl(lo_ctl), .rx_hi_ctl(hi_ctl),
        .out_valid(out_valid), .out_word(out_word), .out_ctl(out_ctl)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_beat(logic [31:0] w, int code, int j);
        int wb = 2 << code;
        logic [31:0] r = '0;
        for (int l = 0; l < 32; l++)
            if (l < wb && j * wb + l < 32) r[l] = w[j * wb + l];
        return r;
    endfunction

    function automatic int cyc_per_word(int code);
        return ((16 >> code) + 1) / 2;
    endfunction

    // R10 scoreboard on the looped-back receive half
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [32:0] e;
            if (exp_q.size() == 0) chk(1'b0, "R10 unexpected word", {31'd0, out_ctl, out_word}, 0);
            else begin
                e = exp_q.pop_front();
                chk({out_ctl, out_word} == e, "R10 rebuilt word", {31'd0, out_ctl, out_word}, {31'd0, e});
            end
        end
    end

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic set_width(input int code, input bit rx_too);
        @(negedge clk);
        while (!(in_ready && !lo_vld)) @(negedge clk);
        cfg_valid = 1'b1;
        cfg_code  = 3'(code);
        @(negedge clk);
        cfg_valid = 1'b0;
        if (rx_too) rx_code = 3'(code);
    endtask

    task automatic send_word(input logic [31:0] w, input logic c);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_word = w; in_ctl = c;
        exp_q.push_back({c, w});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic directed(input int code, input logic [31:0] w, input logic c, input string tag);
        logic [31:0] caps[16];
        int nb = 0;
        int cy = 0;
        int beats = 16 >> code;
        send_word(w, c);
        while (nb < beats && cy < 40) begin
            if (lo_vld) begin
                chk(lo_data == exp_beat(w, code, nb), {tag, " R2 lo beat"}, lo_data, exp_beat(w, code, nb));
                chk(lo_ctl == c, "R7 lo ctl", lo_ctl, c);
                caps[nb[3:0]] = lo_data; nb++;
            end
            if (hi_vld) begin
                chk(hi_data == exp_beat(w, code, nb), {tag, " R2 hi beat"}, hi_data, exp_beat(w, code, nb));
                chk(hi_ctl == c, "R7 hi ctl", hi_ctl, c);
                caps[nb[3:0]] = hi_data; nb++;
            end else if (lo_vld && code == 4) begin
                chk(hi_data == 0 && !hi_ctl, "R5 32-lane second beat empty", hi_data, 0);
            end
            cy++;
            @(negedge clk);
        end
        chk(cy == cyc_per_word(code), {tag, " R5 cycles per word"}, cy, cyc_per_word(code));
        chk(!lo_vld && !lo_ctl, "R7 idle after word", {lo_vld, lo_ctl}, 0);
        if (code == 0) begin
            chk(caps[3][1:0] == w[7:6], "R3 byte0 ends on beat 3", caps[3], w[7:6]);
            chk(caps[4][1:0] == w[9:8], "R3 byte1 starts on beat 4", caps[4], w[9:8]);
        end
        if (code == 1) chk(caps[1][3:0] == w[7:4], "R3 byte0 high nibble on beat 1", caps[1], w[7:4]);
        if (code == 3) begin
            chk(caps[0][15:8] == w[15:8], "R4 byte1 on lane group 1", caps[0], w[15:8]);
            chk(caps[1][7:0] == w[23:16], "R4 byte2 on group 0 of beat 1", caps[1], w[23:16]);
        end
        if (code == 4) chk(caps[0] == w, "R4 all bytes in one beat", caps[0], w);
    endtask

    task automatic drain();
        int k = 0;
        while (exp_q.size() != 0 && k < 400) begin @(negedge clk); k++; end
        chk(exp_q.size() == 0, "R10 all words rebuilt", exp_q.size(), 0);
    endtask

    task automatic throughput(input int code);
        int acc = 0;
        int cpw = cyc_per_word(code);
        set_width(code, 1'b1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_word = $urandom; in_ctl = 1'($urandom % 2);
            if (in_ready) begin acc++; exp_q.push_back({in_ctl, in_word}); end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(acc == (12 + cpw - 1) / cpw, "R6 back-to-back accept count", acc, (12 + cpw - 1) / cpw);
        drain();
    endtask

    task automatic stream(input int n);
        int sent = 0;
        bit hold = 0;
        while (sent < n) begin
            @(negedge clk);
            if (!hold) begin
                if ($urandom % 4 == 0) in_valid = 1'b0;
                else begin in_valid = 1'b1; in_word = $urandom; in_ctl = 1'($urandom % 2); end
            end
            if (in_valid && in_ready) begin exp_q.push_back({in_ctl, in_word}); sent++; hold = 0; end
            else hold = in_valid;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        int wait_n;
        logic [31:0] a_w, b_w;
        void'($urandom(32'h5eed));
        rst_n = 1'b0; cfg_valid = 1'b0; cfg_code = '0;
        in_valid = 1'b0; in_word = '0; in_ctl = 1'b0; rx_code = 3'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready, "R1 ready after reset", in_ready, 1);
        chk(!lo_vld && !hi_vld, "R1 no beats after reset", {lo_vld, hi_vld}, 0);
        chk(!out_valid, "R1 no output after reset", out_valid, 0);
        directed(2, 32'h8765_4321, 1'b1, "R1 default 8 lanes");
        drain();

        for (int c = 0; c < 5; c++) begin
            set_width(c, 1'b1);
            directed(c, 32'hA5C3_1E69 ^ (32'h0101_0101 << c), 1'(c % 2), "R2 width sweep");
            drain();
        end

        for (int c = 0; c < 5; c++) throughput(c);

        for (int r = 0; r < 10; r++) begin
            set_width(int'($urandom % 5), 1'b1);
            stream(20);
            drain();
        end

        // R8: request 32 lanes in the middle of a 2-lane word
        set_width(0, 1'b1);
        a_w = 32'hDEAD_BEEF; b_w = 32'h1357_9BDF;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_word = a_w; in_ctl = 1'b0;
        exp_q.push_back({1'b0, a_w});
        @(negedge clk);
        in_word = b_w; in_ctl = 1'b1;
        cfg_valid = 1'b1; cfg_code = 3'd1;
        @(negedge clk);
        cfg_code = 3'd4;                       // latest request wins
        wait_n = 1;
        @(negedge clk);
        cfg_valid = 1'b0;
        wait_n++;
        while (!in_ready && wait_n < 20) begin @(negedge clk); wait_n++; end
        chk(wait_n == 7, "R8 in-flight word keeps old width", wait_n, 7);
        chk(hi_data == exp_beat(a_w, 0, 15), "R8 last old-width beat", hi_data, exp_beat(a_w, 0, 15));
        exp_q.push_back({1'b1, b_w});
        @(negedge clk);
        in_valid = 1'b0;
        rx_code = 3'd4;
        chk(lo_vld && lo_data == b_w, "R8 next word at new width", lo_data, b_w);
        chk(!hi_vld, "R8 single beat at 32 lanes", hi_vld, 0);
        chk(lo_ctl, "R7 ctl of new word", lo_ctl, 1);
        drain();

        // R9: invalid codes leave the width at 32 lanes
        set_width(6, 1'b0);
        set_width(7, 1'b0);
        directed(4, 32'h0F1E_2D3C, 1'b0, "R9 invalid code ignored");
        drain();
        set_width(3, 1'b1);
        set_width(5, 1'b0);
        directed(3, 32'h7766_5544, 1'b1, "R9 invalid code after valid");
        drain();

        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule